// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a four-wire test access port controller with a boundary-scan chain. It sits between a chip's core logic and its pads. The serial pins step a sixteen-state controller. That controller selects one of three data registers to shift between the serial input and the serial output: a boundary chain, a one-bit bypass stage or a 32-bit identification word. Which register is used depends on a 4-bit instruction.

Each I/O pin owns three chain bits: the pad input, the output value and the output enable. The pin also has two shadow stages that can take over the pad while external test is active. Each internal logic cell owns one chain bit, which only captures and shifts. No dedicated test-reset pin exists. The controller returns to its reset state either from the asynchronous power-on reset or from five consecutive clocks with mode select held high.

Top module: `scan_tap`

## Requirements
- R1: Driving `por_n` low asynchronously puts the controller in its reset state. It also makes the identification instruction active, clears both shadow stages of every pin to 0 and drives `tdo_en` low, so the pads follow the core signals.
- R2: Instruction 4'b0110 (identification, also active after any reset) selects a 32-bit register that captures the `ID_WORD` parameter. The default value is 32'h4A51C0DF, whose bit 0 is 1. The register shifts out bit 0 first.
- R3: The instruction register is 4 bits wide, captures 4'b0001 in Capture-IR and shifts bit 0 out first. The new instruction takes effect only in Update-IR.
- R4: Instruction 4'b1111, and every code not listed in R2, R5, R6 and R7, selects a one-bit bypass stage that captures 0. Serial data therefore appears at `tdo` one clock later, preceded by a 0.
- R5: Instruction 4'b0010 (sample/preload) selects the boundary chain and leaves every pad driven from the core. In Capture-DR the chain loads bit 3i from `pad_in[i]`, bit 3i+1 from `core_out[i]` and bit 3i+2 from `core_oe[i]`. It loads bit 3·NPIN+j from `cell_val[j]`. Bit 0 is nearest `tdo`.
- R6: In Update-DR, under sample/preload or under external test, pin i's output shadow loads chain bit 3i+1 and its enable shadow loads chain bit 3i+2. Under instruction 4'b0000 (external test), `pad_out` and `pad_oe` come from these shadows and not from the core.
- R7: Instruction 4'b0111 (high-impedance) drives every `pad_oe` bit low and selects the bypass stage.
- R8: Five consecutive rising clocks with `tms` high bring the controller to its reset state from any state. That makes the identification instruction active and returns the pads to core control.
- R9: `tdi` and `tms` are sampled on the rising edge of `tck`. `tdo` and `tdo_en` change on the falling edge, and `tdo_en` is high only in Shift-IR and Shift-DR.
- R10: The shadow stages and the active instruction change only on a falling edge in Update-DR or Update-IR (or in the reset state, for the instruction), so pads stay still during a shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| core_out | input | NPIN | Output value from core logic per pin |
| core_oe | input | NPIN | Output enable from core logic per pin |
| pad_in | input | NPIN | Value seen at each pad |
| cell_val | input | NCELL | Internal logic-cell values to observe |
| pad_out | output | NPIN | Value driven toward each pad |
| pad_oe | output | NPIN | Enable driven toward each pad |

## Verification
The bench preloads the shadow stages under sample/preload and checks that the pads ignore them until external test is loaded. A design that updates the pads on preload would change the pads early. The bench also looks at the pads halfway through an external-test shift, where a design with a shadow stage missing would drive the pads with chain bits in motion. The reset paths get their own tests: five mode-select-high clocks and a power-on pulse in the middle of external test must both hand the pads back to the core and restore the identification word. A design that missed either would keep driving test values. The bypass path is checked for the leading 0 and the one-clock delay, for both the defined code and an unused one, so a design that decodes unused codes wrongly or leaves out the bypass stage would give a shifted or missing bit.

// File: rtl/scan_tap.sv
`timescale 1ns/1ps
module scan_tap #(
  parameter int          NPIN    = 4,
  parameter int          NCELL   = 2,
  parameter logic [31:0] ID_WORD = 32'h4A51_C0DF
) (
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  input  logic             por_n,
  output logic             tdo,
  output logic             tdo_en,
  input  logic [NPIN-1:0]  core_out,
  input  logic [NPIN-1:0]  core_oe,
  input  logic [NPIN-1:0]  pad_in,
  input  logic [NCELL-1:0] cell_val,
  output logic [NPIN-1:0]  pad_out,
  output logic [NPIN-1:0]  pad_oe
);
  localparam int CHAIN = 3*NPIN + NCELL;
  localparam logic [3:0] OP_EXT  = 4'b0000;
  localparam logic [3:0] OP_SAMP = 4'b0010;
  localparam logic [3:0] OP_ID   = 4'b0110;
  localparam logic [3:0] OP_HIZ  = 4'b0111;
  localparam logic [3:0] IR_CAP  = 4'b0001;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_t;

  tap_t st, st_nx;

  always_comb begin
    case (st)
      S_TLR:    st_nx = tms ? S_TLR    : S_RTI;
      S_RTI:    st_nx = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: st_nx = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: st_nx = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  st_nx = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: st_nx = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: st_nx = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: st_nx = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: st_nx = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: st_nx = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: st_nx = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  st_nx = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: st_nx = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: st_nx = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: st_nx = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: st_nx = tms ? S_SEL_DR : S_RTI;
      default:  st_nx = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) st <= S_TLR;
    else        st <= st_nx;

  logic [3:0] ir_sr, ir_cur;
  logic       sel_bsr, sel_id, sel_byp;
  assign sel_bsr = (ir_cur == OP_EXT) || (ir_cur == OP_SAMP);
  assign sel_id  = (ir_cur == OP_ID);
  assign sel_byp = !sel_bsr && !sel_id;

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)              ir_sr <= IR_CAP;
    else if (st == S_CAP_IR) ir_sr <= IR_CAP;
    else if (st == S_SH_IR)  ir_sr <= {tdi, ir_sr[3:1]};

  always_ff @(negedge tck or negedge por_n)
    if (!por_n)              ir_cur <= OP_ID;
    else if (st == S_TLR)    ir_cur <= OP_ID;
    else if (st == S_UPD_IR) ir_cur <= ir_sr;

  logic [CHAIN-1:0] cap, bsr;
  logic [31:0]      idr;
  logic             byp;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign cap[3*i]   = pad_in[i];
    assign cap[3*i+1] = core_out[i];
    assign cap[3*i+2] = core_oe[i];
  end
  for (genvar j = 0; j < NCELL; j++) begin : g_cell
    assign cap[3*NPIN+j] = cell_val[j];
  end

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) begin
      bsr <= '0;
      idr <= '0;
      byp <= 1'b0;
    end else begin
      if (sel_bsr && st == S_CAP_DR)     bsr <= cap;
      else if (sel_bsr && st == S_SH_DR) bsr <= {tdi, bsr[CHAIN-1:1]};
      if (sel_id && st == S_CAP_DR)      idr <= ID_WORD;
      else if (sel_id && st == S_SH_DR)  idr <= {tdi, idr[31:1]};
      if (sel_byp && st == S_CAP_DR)     byp <= 1'b0;
      else if (sel_byp && st == S_SH_DR) byp <= tdi;
    end

  logic [NPIN-1:0] upd_out, upd_oe;
  always_ff @(negedge tck or negedge por_n)
    if (!por_n) begin
      upd_out <= '0;
      upd_oe  <= '0;
    end else if (st == S_UPD_DR && sel_bsr) begin
      for (int i = 0; i < NPIN; i++) begin
        upd_out[i] <= bsr[3*i+1];
        upd_oe[i]  <= bsr[3*i+2];
      end
    end

  logic dr_bit;
  assign dr_bit = sel_bsr ? bsr[0] : (sel_id ? idr[0] : byp);

  always_ff @(negedge tck or negedge por_n)
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= (st == S_SH_IR) ? ir_sr[0] : dr_bit;
      tdo_en <= (st == S_SH_IR) || (st == S_SH_DR);
    end

  assign pad_out = (ir_cur == OP_EXT) ? upd_out : core_out;
  assign pad_oe  = (ir_cur == OP_EXT) ? upd_oe  :
                   (ir_cur == OP_HIZ) ? '0      : core_oe;

  logic [2:0] ones_cnt;
  always_ff @(posedge tck or negedge por_n)
    if (!por_n)      ones_cnt <= '0;
    else if (!tms)   ones_cnt <= '0;
    else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;

  p_five_ones_r8: assert property (@(posedge tck) disable iff (!por_n)
    (ones_cnt == 3'd5) |-> (st == S_TLR));

  p_reset_id_r2: assert property (@(posedge tck) disable iff (!por_n)
    (st == S_TLR) |-> (ir_cur == OP_ID));

  p_ir_capture_r3: assert property (@(posedge tck) disable iff (!por_n)
    (st == S_CAP_IR) |=> (ir_sr == IR_CAP));

  p_byp_zero_r4: assert property (@(posedge tck) disable iff (!por_n)
    (st == S_CAP_DR && sel_byp) |=> (byp == 1'b0));

  p_hiz_oe_r7: assert property (@(posedge tck) disable iff (!por_n)
    (ir_cur == OP_HIZ) |-> (pad_oe == '0));

  p_shadow_still_r10: assert property (@(negedge tck) disable iff (!por_n)
    (st == S_SH_DR) |=> ($stable(upd_out) && $stable(upd_oe)));

  p_tdo_idle_r9: assert property (@(posedge tck) disable iff (!por_n)
    (st == S_RTI && $past(st) == S_RTI) |-> !tdo_en);
endmodule

// File: tb/sim_scan_tap.sv
`timescale 1ns/1ps
module sim_scan_tap;
  localparam int NP = 4;
  localparam int NC = 2;
  localparam int L  = 3*NP + NC;
  localparam logic [31:0] IDV = 32'h4A51_C0DF;

  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, por_n = 1'b0;
  logic tdo, tdo_en;
  logic [NP-1:0] core_out = '0, core_oe = '0, pad_in = '0, pad_out, pad_oe;
  logic [NC-1:0] cell_val = '0;
  int checks = 0, errors = 0;

  scan_tap #(.NPIN(NP), .NCELL(NC), .ID_WORD(IDV)) u0 (
    .tck(tck), .tms(tms), .tdi(tdi), .por_n(por_n), .tdo(tdo), .tdo_en(tdo_en),
    .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in), .cell_val(cell_val),
    .pad_out(pad_out), .pad_oe(pad_oe));

  always #2 tck = ~tck;

  // {core_out, core_oe, pad_in, cell_val}
  localparam logic [13:0] VEC [4] = '{
    {4'b1010, 4'b1100, 4'b0110, 2'b01},
    {4'b0101, 4'b0011, 4'b1001, 2'b10},
    {4'b1111, 4'b0000, 4'b0000, 2'b11},
    {4'b0000, 4'b1111, 4'b1111, 2'b00}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    check("R9 tdo_en in Shift-DR", {63'd0, tdo_en}, 64'd1);
    for (int k = 0; k < n; k++) begin
      dout[k] = tdo;
      step(k == n-1, din[k]);
    end
    check("R9 tdo_en after Shift-DR", {63'd0, tdo_en}, 64'd0);
    step(1, 0); step(0, 0);
  endtask

  task automatic shift_ir(input logic [3:0] code, output logic [3:0] capv);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 4; k++) begin
      capv[k] = tdo;
      step(k == 3, code[k]);
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [L-1:0] exp_chain(logic [13:0] v);
    logic [L-1:0] c;
    for (int i = 0; i < NP; i++) begin
      c[3*i]   = v[2+i];
      c[3*i+1] = v[10+i];
      c[3*i+2] = v[6+i];
    end
    for (int j = 0; j < NC; j++) c[3*NP+j] = v[j];
    return c;
  endfunction

  function automatic logic [63:0] mk_chain(logic [NP-1:0] o, logic [NP-1:0] e);
    logic [63:0] c = '0;
    for (int i = 0; i < NP; i++) begin
      c[3*i+1] = o[i];
      c[3*i+2] = e[i];
    end
    return c;
  endfunction

  initial begin
    #(200000*4);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [3:0]  c;
    logic [63:0] pre, nxt;
    core_out = 4'b1001; core_oe = 4'b0110;
    #9;
    check("R1 tdo_en low in reset", {63'd0, tdo_en}, 64'd0);
    check("R1 pads follow core", {56'd0, pad_out, pad_oe}, {56'd0, 4'b1001, 4'b0110});
    por_n = 1'b1;
    @(negedge tck); #1;
    step(0, 0);
    check("R9 tdo_en idle", {63'd0, tdo_en}, 64'd0);

    shift_dr(32, 64'd0, d);
    check("R2 ID word after reset", d, {32'd0, IDV});

    shift_ir(4'b0010, c);
    check("R3 IR capture pattern", {60'd0, c}, 64'd1);

    for (int t = 0; t < 4; t++) begin
      {core_out, core_oe, pad_in, cell_val} = VEC[t];
      shift_dr(L, 64'd0, d);
      check("R5 chain capture", d, {{(64-L){1'b0}}, exp_chain(VEC[t])});
      check("R5 pads follow core in sample", {56'd0, pad_out, pad_oe},
            {56'd0, VEC[t][13:10], VEC[t][9:6]});
    end

    core_out = 4'b0000; core_oe = 4'b0000;
    pre = mk_chain(4'b1011, 4'b0110);
    shift_dr(L, pre, d);
    check("R6 preload leaves pads on core", {56'd0, pad_out, pad_oe}, 64'd0);
    shift_ir(4'b0000, c);
    check("R6 extest drives shadows", {56'd0, pad_out, pad_oe}, {56'd0, 4'b1011, 4'b0110});

    nxt = mk_chain(4'b0100, 4'b1001);
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < L; k++) begin
      if (k == L/2)
        check("R10 pads still mid-shift", {56'd0, pad_out, pad_oe}, {56'd0, 4'b1011, 4'b0110});
      step(k == L-1, nxt[k]);
    end
    check("R10 pads still in Exit1", {56'd0, pad_out, pad_oe}, {56'd0, 4'b1011, 4'b0110});
    step(1, 0); step(0, 0);
    check("R6 update loads new shadows", {56'd0, pad_out, pad_oe}, {56'd0, 4'b0100, 4'b1001});

    for (int k = 0; k < 5; k++) step(1, 0);
    check("R8 five ones release pads", {56'd0, pad_out, pad_oe}, 64'd0);
    step(0, 0);
    shift_dr(32, 64'd0, d);
    check("R8 ID after five ones", d, {32'd0, IDV});

    shift_ir(4'b1111, c);
    shift_dr(8, 64'hB6, d);
    check("R4 bypass one-bit delay", d, 64'h6C);
    shift_ir(4'b0101, c);
    shift_dr(8, 64'h3A, d);
    check("R4 unused code bypass", d, 64'h74);

    core_out = 4'b1100; core_oe = 4'b1111;
    shift_ir(4'b0111, c);
    check("R7 highz forces oe low", {56'd0, pad_out, pad_oe}, {56'd0, 4'b1100, 4'b0000});
    shift_dr(4, 64'h5, d);
    check("R7 highz uses bypass", d, 64'hA);

    shift_ir(4'b0110, c);
    shift_dr(32, 64'd0, d);
    check("R2 ID by instruction", d, {32'd0, IDV});

    core_out = 4'b0000; core_oe = 4'b0000;
    shift_ir(4'b0010, c);
    shift_dr(L, mk_chain(4'b1111, 4'b1111), d);
    shift_ir(4'b0000, c);
    check("R6 extest before por", {56'd0, pad_out, pad_oe}, 64'hFF);
    por_n = 1'b0; #1;
    check("R1 por returns pads to core", {56'd0, pad_out, pad_oe}, 64'd0);
    check("R1 por drops tdo_en", {63'd0, tdo_en}, 64'd0);
    @(negedge tck); #1;
    por_n = 1'b1;
    step(0, 0);
    shift_dr(32, 64'd0, d);
    check("R1 ID after por", d, {32'd0, IDV});
    shift_ir(4'b0000, c);
    check("R1 shadows cleared by por", {56'd0, pad_out, pad_oe}, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule